// File: doc/BRIEF.md
# Prescaled Timer Counter With Compare Match and Waveform Pin

The block is an up-counter, 32 bits wide by default, for free-running time bases, one-shot delays and simple waveform generation. A single configuration write sets the following:

- start, and reload on wrap;
- an optional power-of-two clock divider;
- compare enable;
- the rest level of the waveform pin, the event that moves the pin, and whether the pin toggles or pulses;
- the direction of the pin.

Software can also do three other things. It can set the count directly. It can store a reload value and a compare value. It can copy the reload value into the counter by writing a trigger strobe, whatever data goes with it.

Each wrap past the all-ones count and each compare hit is reported as a one-cycle event. The pin follows these events only when the counter runs and a trigger mode is selected. Otherwise it rests at the programmed level. The write strobes are sampled on the rising clock edge, all together with one data bus. An outer register interface is expected to decode addresses into these strobes.

Top module: `tmr_match_pwm`

## Requirements
- R1: After reset `count` is 0, `ovf_evt`, `match_evt` and `pin_out` are 0 and `pin_oe` is 1.
- R2: With control bit 0 (start) set and bit 5 clear, `count` rises by one on every clock edge, starting at the edge after the control write. With start clear, `count` holds.
- R3: With control bit 5 set, the counter advances once every 2^(e+1) clocks, where e is control bits 4:2.
- R4: When the counter advances from all ones with control bit 1 (reload) set, `count` takes the reload value and keeps running. `ovf_evt` is high for exactly that one cycle.
- R5: When the counter advances from all ones with reload clear, `count` becomes 0, start clears, the count then holds, and `ovf_evt` pulses once.
- R6: With control bit 6 set, `match_evt` is high for one cycle after the counter advances onto the compare value. With bit 6 clear, `match_evt` never rises.
- R7: Control bits 11:10 pick the pin trigger. 1 means on wrap only, where a compare hit has no effect on the pin. 2 means on both wrap and compare hit. 0 and 3 mean none.
- R8: With control bit 12 set, the pin inverts on each trigger event.
- R9: With control bit 12 clear, the pin shows the inverse of the rest level for exactly one cycle on each trigger event.
- R10: While start is clear or the trigger mode is none, the pin goes to the rest level, control bit 7, one cycle later.
- R11: A trigger-strobe write copies the reload value into `count` at that edge, whatever the data bus carries.
- R12: A direct count write sets `count` to the data at that edge. It takes priority over the advance due in that cycle.
- R13: Every control write restarts the divider, so the first advance after it comes a full 2^(e+1) clocks later.
- R14: `pin_oe` is the inverse of control bit 14. A 1 in that bit makes the pin an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | CNT_W | Write data shared by all strobes |
| ctrl_wr | input | 1 | Write the control register |
| cnt_wr | input | 1 | Write the count directly |
| reload_wr | input | 1 | Write the reload value |
| trig_wr | input | 1 | Copy the reload value into the count |
| match_wr | input | 1 | Write the compare value |
| count | output | CNT_W | Current count |
| ovf_evt | output | 1 | One-cycle wrap event |
| match_evt | output | 1 | One-cycle compare event |
| pin_out | output | 1 | Waveform pin level |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hard cases all sit at the top of a 32-bit range, where wraps and compare hits happen. Reaching them by counting would take billions of cycles. The stimulus therefore writes a count a few steps below all ones, together with a nearby reload and compare value, and then starts the counter. This makes wrap, reload, stop and compare hits come back within a handful of cycles, so that toggle and pulse waveforms can be followed edge by edge. The divider restart is reached by writing the same control value again partway through a divided period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int EXP_W = 3;

    typedef struct packed {
        logic             dir;
        logic             pt;
        logic [1:0]       trig;
        logic             dflt;
        logic             ce;
        logic             pre;
        logic [EXP_W-1:0] ptv;
        logic             ar;
        logic             start;
    } tmr_ctrl_t;

    localparam logic [1:0] TRIG_OVF  = 2'd1;
    localparam logic [1:0] TRIG_BOTH = 2'd2;

    function automatic tmr_ctrl_t decode_ctrl(input logic [14:0] v);
        tmr_ctrl_t c;
        c.start = v[0];
        c.ar    = v[1];
        c.ptv   = v[4:2];
        c.pre   = v[5];
        c.ce    = v[6];
        c.dflt  = v[7];
        c.trig  = v[11:10];
        c.pt    = v[12];
        c.dir   = v[14];
        return c;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ctrl_wr,
    input  logic             reload_wr,
    input  logic             match_wr,
    input  logic             stop_req,
    output tmr_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] match_q
);

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] match;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.ctrl = decode_ctrl(wdata[14:0]);
        end else if (stop_req) begin
            r_d.ctrl.start = 1'b0;
        end
        if (reload_wr) r_d.reload = wdata;
        if (match_wr)  r_d.match  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_q   = r_q.ctrl;
    assign reload_q = r_q.reload;
    assign match_q  = r_q.match;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] ptv,
    input  logic             restart,
    output logic             tick
);

    localparam int DIV_W = (1 << EXP_W) + 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = (DIV_W'(1) << (DIV_W'(ptv) + DIV_W'(1))) - DIV_W'(1);
        tick = run && (!pre_en || (div_q == last));
        if (restart || !run || !pre_en || (div_q == last)) div_d = '0;
        else                                               div_d = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ar,
    input  logic             ce,
    input  logic [CNT_W-1:0] reload_q,
    input  logic [CNT_W-1:0] match_q,
    input  logic [CNT_W-1:0] wdata,
    input  logic             cnt_wr,
    input  logic             trig_wr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             match_evt,
    output logic             ovf_now,
    output logic             match_now,
    output logic             stop_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             mat;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [CNT_W-1:0] adv;
    logic             advance;

    always_comb begin
        advance   = tick && !cnt_wr && !trig_wr;
        ovf_now   = advance && (c_q.cnt == '1);
        if (c_q.cnt == '1) adv = ar ? reload_q : '0;
        else               adv = c_q.cnt + CNT_W'(1);
        match_now = advance && ce && (adv == match_q);
        stop_req  = ovf_now && !ar;

        c_d     = c_q;
        c_d.ovf = ovf_now;
        c_d.mat = match_now;
        if (cnt_wr)       c_d.cnt = wdata;
        else if (trig_wr) c_d.cnt = reload_q;
        else if (advance) c_d.cnt = adv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count     = c_q.cnt;
    assign ovf_evt   = c_q.ovf;
    assign match_evt = c_q.mat;

endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] trig,
    input  logic       pt,
    input  logic       dflt,
    input  logic       dir,
    input  logic       ovf_now,
    input  logic       match_now,
    output logic       pin_out,
    output logic       pin_oe
);

    logic level_d, level_q;
    logic active, fire;

    always_comb begin
        active = start && ((trig == TRIG_OVF) || (trig == TRIG_BOTH));
        fire   = ((trig == TRIG_OVF) && ovf_now) ||
                 ((trig == TRIG_BOTH) && (ovf_now || match_now));
        if (!active) level_d = dflt;
        else if (pt) level_d = level_q ^ fire;
        else         level_d = dflt ^ fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_d;
    end

    assign pin_out = level_q;
    assign pin_oe  = !dir;

endmodule

// File: rtl/tmr_match_pwm.sv
module tmr_match_pwm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ctrl_wr,
    input  logic             cnt_wr,
    input  logic             reload_wr,
    input  logic             trig_wr,
    input  logic             match_wr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             match_evt,
    output logic             pin_out,
    output logic             pin_oe
);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] match_q;
    logic             stop_req;
    logic             tick;
    logic             ovf_now;
    logic             match_now;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wdata(wdata), .ctrl_wr(ctrl_wr),
        .reload_wr(reload_wr), .match_wr(match_wr), .stop_req(stop_req),
        .ctrl_q(ctrl_q), .reload_q(reload_q), .match_q(match_q)
    );

    tmr_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.start), .pre_en(ctrl_q.pre),
        .ptv(ctrl_q.ptv), .restart(ctrl_wr), .tick(tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ar(ctrl_q.ar), .ce(ctrl_q.ce),
        .reload_q(reload_q), .match_q(match_q), .wdata(wdata),
        .cnt_wr(cnt_wr), .trig_wr(trig_wr), .count(count),
        .ovf_evt(ovf_evt), .match_evt(match_evt), .ovf_now(ovf_now),
        .match_now(match_now), .stop_req(stop_req)
    );

    tmr_pin u_pin (
        .clk(clk), .rst_n(rst_n), .start(ctrl_q.start), .trig(ctrl_q.trig),
        .pt(ctrl_q.pt), .dflt(ctrl_q.dflt), .dir(ctrl_q.dir),
        .ovf_now(ovf_now), .match_now(match_now),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

endmodule

// File: rtl/tmr_match_pwm_chk.sv
module tmr_match_pwm_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] wdata,
    input logic             ctrl_wr,
    input logic             cnt_wr,
    input logic             trig_wr,
    input logic             match_wr,
    input logic [CNT_W-1:0] count,
    input logic             ovf_evt,
    input logic             match_evt,
    input logic             pin_out,
    input logic             pin_oe,
    input tmr_ctrl_t        ctrl_q,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] match_q
);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.start && !cnt_wr && !trig_wr) |=> $stable(count));

    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !$past(ctrl_q.ar) && !$past(ctrl_wr)) |-> (count == '0 && !ctrl_q.start));

    p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !$past(match_wr)) |-> (count == match_q));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.start || ctrl_q.trig == 2'd0 || ctrl_q.trig == 2'd3) |=> (pin_out == $past(ctrl_q.dflt)));

    p_trig_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && !cnt_wr) |=> (count == $past(reload_q)));

    p_direct_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata)));

    p_dir_r14: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (pin_oe == !$past(wdata[14])));

endmodule

bind tmr_match_pwm tmr_match_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .ctrl_wr(ctrl_wr),
    .cnt_wr(cnt_wr), .trig_wr(trig_wr), .match_wr(match_wr),
    .count(count), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_q(ctrl_q),
    .reload_q(reload_q), .match_q(match_q)
);

// File: tb/tb_tmr_match_pwm.sv
module tb_tmr_match_pwm;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wdata = '0;
    logic        ctrl_wr = 1'b0, cnt_wr = 1'b0, reload_wr = 1'b0;
    logic        trig_wr = 1'b0, match_wr = 1'b0;
    logic [31:0] count;
    logic        ovf_evt, match_evt, pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_match_pwm dut (
        .clk(clk), .rst_n(rst_n), .wdata(wdata), .ctrl_wr(ctrl_wr),
        .cnt_wr(cnt_wr), .reload_wr(reload_wr), .trig_wr(trig_wr),
        .match_wr(match_wr), .count(count), .ovf_evt(ovf_evt),
        .match_evt(match_evt), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sel: 0 ctrl, 1 count, 2 reload, 3 trigger, 4 match
    task automatic wr(input int sel, input logic [31:0] d);
        wdata     = d;
        ctrl_wr   = (sel == 0);
        cnt_wr    = (sel == 1);
        reload_wr = (sel == 2);
        trig_wr   = (sel == 3);
        match_wr  = (sel == 4);
        @(negedge clk);
        {ctrl_wr, cnt_wr, reload_wr, trig_wr, match_wr} = '0;
        wdata = '0;
    endtask

    task automatic t_reset;
        chk("R1 count", count, 0);
        chk("R1 ovf", {31'b0, ovf_evt}, 0);
        chk("R1 match", {31'b0, match_evt}, 0);
        chk("R1 pin", {31'b0, pin_out}, 0);
        chk("R1 oe", {31'b0, pin_oe}, 1);
    endtask

    task automatic t_count_r2;
        wr(0, 32'h0); wr(1, 32'h0);
        wr(0, 32'h1);
        chk("R2 first", count, 0);
        step(5);
        chk("R2 running", count, 5);
        wr(0, 32'h0);
        step(4);
        chk("R2 hold", count, 6);
    endtask

    task automatic t_prescale_r3;
        wr(0, 32'h0); wr(1, 32'h0);
        wr(0, 32'h25);
        step(7);
        chk("R3 e1 seven", count, 1);
        step(1);
        chk("R3 e1 eight", count, 2);
        wr(0, 32'h0); wr(1, 32'h0);
        wr(0, 32'h21);
        step(6);
        chk("R3 e0 six", count, 3);
    endtask

    task automatic t_restart_r13;
        wr(0, 32'h0); wr(1, 32'h0);
        wr(0, 32'h25);
        step(2);
        wr(0, 32'h25);
        step(3);
        chk("R13 no early tick", count, 0);
        step(1);
        chk("R13 full period", count, 1);
    endtask

    task automatic t_reload_r4;
        wr(0, 32'h0); wr(2, 32'h100); wr(1, 32'hFFFF_FFFD);
        wr(0, 32'h3);
        step(2);
        chk("R4 top", count, 32'hFFFF_FFFF);
        chk("R4 no ovf yet", {31'b0, ovf_evt}, 0);
        step(1);
        chk("R4 reload", count, 32'h100);
        chk("R4 ovf", {31'b0, ovf_evt}, 1);
        step(1);
        chk("R4 runs on", count, 32'h101);
        chk("R4 ovf one cycle", {31'b0, ovf_evt}, 0);
    endtask

    task automatic t_stop_r5;
        wr(0, 32'h0); wr(1, 32'hFFFF_FFFE);
        wr(0, 32'h1);
        step(2);
        chk("R5 zero", count, 0);
        chk("R5 ovf", {31'b0, ovf_evt}, 1);
        step(3);
        chk("R5 stopped", count, 0);
        chk("R5 ovf once", {31'b0, ovf_evt}, 0);
    endtask

    task automatic t_match_r6;
        int seen;
        wr(0, 32'h0); wr(4, 32'd10); wr(1, 32'd5);
        wr(0, 32'h41);
        step(4);
        chk("R6 before", {31'b0, match_evt}, 0);
        step(1);
        chk("R6 count", count, 10);
        chk("R6 event", {31'b0, match_evt}, 1);
        step(1);
        chk("R6 one cycle", {31'b0, match_evt}, 0);
        wr(0, 32'h0); wr(1, 32'd5);
        wr(0, 32'h1);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (match_evt) seen++;
        end
        chk("R6 disabled", seen, 0);
    endtask

    task automatic t_toggle_r8;
        wr(0, 32'h0); step(1);
        wr(2, 32'hFFFF_FFFC); wr(1, 32'hFFFF_FFFC); wr(4, 32'hFFFF_FFFE);
        // start, reload, compare, trigger mode 1, toggle
        wr(0, 32'h1443);
        chk("R8 idle low", {31'b0, pin_out}, 0);
        step(2);
        chk("R7 match ignored in mode 1", {31'b0, pin_out}, 0);
        step(2);
        chk("R8 toggle high", {31'b0, pin_out}, 1);
        step(3);
        chk("R8 holds", {31'b0, pin_out}, 1);
        step(1);
        chk("R8 toggle low", {31'b0, pin_out}, 0);
    endtask

    task automatic t_pulse_r9;
        wr(0, 32'h80); step(1);
        chk("R10 rest high", {31'b0, pin_out}, 1);
        wr(2, 32'hFFFF_FFFC); wr(1, 32'hFFFF_FFFC); wr(4, 32'hFFFF_FFFE);
        // start, reload, compare, rest high, trigger mode 2, pulse
        wr(0, 32'h8C3);
        step(1);
        chk("R9 quiet", {31'b0, pin_out}, 1);
        step(1);
        chk("R7 R9 match pulse", {31'b0, pin_out}, 0);
        step(1);
        chk("R9 pulse ends", {31'b0, pin_out}, 1);
        step(1);
        chk("R9 overflow pulse", {31'b0, pin_out}, 0);
        step(1);
        chk("R9 overflow ends", {31'b0, pin_out}, 1);
    endtask

    task automatic t_idle_r10;
        wr(0, 32'h0); step(1);
        wr(0, 32'h81);
        step(1);
        chk("R10 mode 0 rest", {31'b0, pin_out}, 1);
        wr(0, 32'h0);
        step(1);
        chk("R10 stopped rest", {31'b0, pin_out}, 0);
        wr(0, 32'hC81);
        step(1);
        chk("R10 mode 3 rest", {31'b0, pin_out}, 1);
        wr(0, 32'h0);
    endtask

    task automatic t_trig_r11;
        wr(0, 32'h0); wr(2, 32'h1234);
        wr(3, 32'hDEAD_BEEF);
        chk("R11 copy", count, 32'h1234);
        step(2);
        chk("R11 held", count, 32'h1234);
    endtask

    task automatic t_direct_r12;
        wr(0, 32'h0); wr(1, 32'h0);
        wr(0, 32'h1);
        step(2);
        wr(1, 32'h50);
        chk("R12 direct", count, 32'h50);
        step(3);
        chk("R12 continues", count, 32'h53);
        wr(0, 32'h0);
    endtask

    task automatic t_dir_r14;
        wr(0, 32'h4000);
        chk("R14 input", {31'b0, pin_oe}, 0);
        wr(0, 32'h0);
        chk("R14 output", {31'b0, pin_oe}, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_count_r2();
        t_prescale_r3();
        t_restart_r13();
        t_reload_r4();
        t_stop_r5();
        t_match_r6();
        t_toggle_r8();
        t_pulse_r9();
        t_idle_r10();
        t_trig_r11();
        t_direct_r12();
        t_dir_r14();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule